// File: doc/BRIEF.md
# Dual-Port Address-Collision Arbiter

This block sits beside a RAM that two independent ports (left and right) share. Every clock cycle it looks at each port's chip enable (active low) and address. When both ports are enabled and point at the same word, the two accesses collide. The block then gives the word to one port and raises an active-low busy flag toward the other. The losing port's write strobe is suppressed before it reaches the array. Whether either access is a read or a write plays no part in who wins.

The winner is the port whose enable and address were already in place when the other port arrived. A port counts as already in place when it was enabled on the same address in the previous clock cycle. If both ports arrive in the same cycle, the left port wins. The owner is kept in a register until the collision ends, so the grant never swaps sides partway through.

A mode input picks between master and slave behaviour:
- **Master:** the block decides ownership and drives the busy outputs.
- **Slave:** the busy outputs stay idle, and each port's busy input acts purely as a write inhibit. Several arrays can then follow one deciding master.

Top module: `dpcoll_arbiter`

## Requirements
- R1: During and directly after reset, both busy outputs are high (idle) and no owner is held.
- R2: If either chip enable is high or the two addresses differ, both busy outputs are high one clock edge later, and each gated write equals its port's write input.
- R3: In master mode, when one port has been enabled on an address for at least one cycle and the other port then becomes enabled on that same address, the newcomer's busy output goes low at the next edge. The established port's busy output stays high.
- R4: In master mode, when both ports start a matching access in the same cycle, the left port wins: the right busy output goes low and the left busy output stays high.
- R5: While the collision persists, the recorded owner does not change, whatever the write inputs do.
- R6: The choice of winner is the same for every combination of the two write inputs (low = write, high = read).
- R7: The two busy outputs are never low at the same time.
- R8: In master mode, the losing port's gated write is forced high in the same cycle its loss is decided. The winning port's gated write follows its write input.
- R9: A collision ends when the addresses stop matching or either enable goes high. Both busy outputs return high at the next edge.
- R10: In slave mode both busy outputs stay high. A low busy input forces that port's gated write high, and a high busy input lets that port's write input through.
- R11: In master mode the busy inputs have no effect on the gated writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 = master (decides, drives busy), 0 = slave (busy inputs inhibit writes) |
| left_ce_n | input | 1 | Left chip enable, active low |
| left_addr | input | ADDR_W | Left word address |
| left_we_n | input | 1 | Left write strobe, active low |
| left_busy_in_n | input | 1 | Left busy input used in slave mode, active low |
| right_ce_n | input | 1 | Right chip enable, active low |
| right_addr | input | ADDR_W | Right word address |
| right_we_n | input | 1 | Right write strobe, active low |
| right_busy_in_n | input | 1 | Right busy input used in slave mode, active low |
| left_busy_out_n | output | 1 | Registered busy toward the left port, active low |
| right_busy_out_n | output | 1 | Registered busy toward the right port, active low |
| left_we_gated_n | output | 1 | Left write strobe after collision gating, active low |
| right_we_gated_n | output | 1 | Right write strobe after collision gating, active low |

## Verification
The hardest situation to reach from the ports is a collision in which one side was already settled on the address for a cycle before the other side arrived. Reaching it also requires that the collision is then held for several cycles while the write strobes change. Directed sequences build this up in steps: the first port is parked on the word, the second port joins it, and the write inputs are then toggled on both sides while the addresses stay matched. A long pseudo-random sweep over a two-bit address space causes frequent matches, including same-cycle arrivals and mode switches in the middle of a collision. A cycle model in the bench, written from the requirements, predicts every output.

// File: rtl/dpcoll_pkg.sv
package dpcoll_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Winner for a fresh collision: the side already settled wins, left on a tie.
  function automatic owner_e pick_owner(input logic l_settled, input logic r_settled);
    return (r_settled && !l_settled) ? OWN_RIGHT : OWN_LEFT;
  endfunction

  // Write strobe after inhibit, active low.
  function automatic logic gate_write(input logic we_n, input logic inhibit);
    return we_n | inhibit;
  endfunction

endpackage

// File: rtl/dpcoll_port_track.sv
module dpcoll_port_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              prev_en_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en_q   <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_en_q   <= !ce_n;
      prev_addr_q <= addr;
    end
  end

  assign settled = prev_en_q && !ce_n && (prev_addr_q == addr);
endmodule

// File: rtl/dpcoll_owner.sv
module dpcoll_owner
  import dpcoll_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   collide,
  input  logic   l_settled,
  input  logic   r_settled,
  output owner_e own_nxt
);
  owner_e own_q;

  always_comb begin
    if (!collide)
      own_nxt = OWN_NONE;
    else if (own_q != OWN_NONE)
      own_nxt = own_q;
    else
      own_nxt = pick_owner(l_settled, r_settled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_nxt;
  end
endmodule

// File: rtl/dpcoll_gate.sv
module dpcoll_gate
  import dpcoll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic lose,
  input  logic busy_in_n,
  input  logic we_n,
  output logic busy_out_n,
  output logic we_gated_n
);
  logic inhibit;

  assign inhibit    = is_master ? lose : !busy_in_n;
  assign we_gated_n = gate_write(we_n, inhibit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_out_n <= 1'b1;
    else        busy_out_n <= !(is_master && lose);
  end
endmodule

// File: rtl/dpcoll_arbiter.sv
module dpcoll_arbiter
  import dpcoll_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              left_ce_n,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic              left_we_n,
  input  logic              left_busy_in_n,
  input  logic              right_ce_n,
  input  logic [ADDR_W-1:0] right_addr,
  input  logic              right_we_n,
  input  logic              right_busy_in_n,
  output logic              left_busy_out_n,
  output logic              right_busy_out_n,
  output logic              left_we_gated_n,
  output logic              right_we_gated_n
);
  localparam int NP = 2;

  logic              ce_v     [NP];
  logic [ADDR_W-1:0] addr_v   [NP];
  logic              we_v     [NP];
  logic              bin_v    [NP];
  logic              settled_v[NP];
  logic              lose_v   [NP];
  logic              bout_v   [NP];
  logic              wg_v     [NP];
  logic              collide;
  owner_e            own_nxt;

  assign ce_v[0]   = left_ce_n;       assign ce_v[1]   = right_ce_n;
  assign addr_v[0] = left_addr;       assign addr_v[1] = right_addr;
  assign we_v[0]   = left_we_n;       assign we_v[1]   = right_we_n;
  assign bin_v[0]  = left_busy_in_n;  assign bin_v[1]  = right_busy_in_n;

  assign collide = !left_ce_n && !right_ce_n && (left_addr == right_addr);

  dpcoll_owner u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .collide   (collide),
    .l_settled (settled_v[0]),
    .r_settled (settled_v[1]),
    .own_nxt   (own_nxt)
  );

  for (genvar g = 0; g < NP; g++) begin : g_port
    dpcoll_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_v[g]),
      .addr    (addr_v[g]),
      .settled (settled_v[g])
    );

    assign lose_v[g] = (own_nxt == ((g == 0) ? OWN_RIGHT : OWN_LEFT));

    dpcoll_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_master  (is_master),
      .lose       (lose_v[g]),
      .busy_in_n  (bin_v[g]),
      .we_n       (we_v[g]),
      .busy_out_n (bout_v[g]),
      .we_gated_n (wg_v[g])
    );
  end

  assign left_busy_out_n  = bout_v[0];
  assign right_busy_out_n = bout_v[1];
  assign left_we_gated_n  = wg_v[0];
  assign right_we_gated_n = wg_v[1];
endmodule

// File: rtl/dpcoll_arbiter_chk.sv
module dpcoll_arbiter_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              is_master,
  input logic              left_ce_n,
  input logic [ADDR_W-1:0] left_addr,
  input logic              left_busy_in_n,
  input logic              right_ce_n,
  input logic [ADDR_W-1:0] right_addr,
  input logic              right_busy_in_n,
  input logic              left_busy_out_n,
  input logic              right_busy_out_n,
  input logic              left_we_gated_n,
  input logic              right_we_gated_n
);
  logic hit;
  assign hit = !left_ce_n && !right_ce_n && (left_addr == right_addr);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    left_busy_out_n || right_busy_out_n);

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (left_busy_out_n && right_busy_out_n));

  p_slave_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> (left_busy_out_n && right_busy_out_n));

  p_hold_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && hit && !left_busy_out_n) |=> !left_busy_out_n);

  p_hold_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && hit && !right_busy_out_n) |=> !right_busy_out_n);

  p_block_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && hit && !left_busy_out_n) |-> left_we_gated_n);

  p_block_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && hit && !right_busy_out_n) |-> right_we_gated_n);

  p_slave_inhibit_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !left_busy_in_n) |-> left_we_gated_n);

  p_slave_inhibit_right_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !right_busy_in_n) |-> right_we_gated_n);
endmodule

bind dpcoll_arbiter dpcoll_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .is_master        (is_master),
  .left_ce_n        (left_ce_n),
  .left_addr        (left_addr),
  .left_busy_in_n   (left_busy_in_n),
  .right_ce_n       (right_ce_n),
  .right_addr       (right_addr),
  .right_busy_in_n  (right_busy_in_n),
  .left_busy_out_n  (left_busy_out_n),
  .right_busy_out_n (right_busy_out_n),
  .left_we_gated_n  (left_we_gated_n),
  .right_we_gated_n (right_we_gated_n)
);

// File: tb/dpcoll_arbiter_test.sv
module dpcoll_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          is_master = 1'b1;
  logic          l_ce = 1'b1, r_ce = 1'b1;
  logic [AW-1:0] l_a = '0, r_a = '0;
  logic          l_we = 1'b1, r_we = 1'b1;
  logic          l_bi = 1'b1, r_bi = 1'b1;
  logic          l_bo, r_bo, l_wg, r_wg;

  int checks = 0;
  int errors = 0;

  // bench model state: owner 0 none, 1 left, 2 right
  int            m_owner = 0;
  logic          m_pen [2] = '{1'b0, 1'b0};
  logic [AW-1:0] m_pad [2] = '{'0, '0};

  always #(CLK_PERIOD/2) clk = ~clk;

  dpcoll_arbiter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .left_ce_n(l_ce), .left_addr(l_a), .left_we_n(l_we), .left_busy_in_n(l_bi),
    .right_ce_n(r_ce), .right_addr(r_a), .right_we_n(r_we), .right_busy_in_n(r_bi),
    .left_busy_out_n(l_bo), .right_busy_out_n(r_bo),
    .left_we_gated_n(l_wg), .right_we_gated_n(r_wg)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic mst,
                      input logic lce, input logic [AW-1:0] la, input logic lwe, input logic lbi,
                      input logic rce, input logic [AW-1:0] ra, input logic rwe, input logic rbi);
    logic coll, lh, rh;
    int   nxt;
    @(negedge clk);
    is_master = mst;
    l_ce = lce; l_a = la; l_we = lwe; l_bi = lbi;
    r_ce = rce; r_a = ra; r_we = rwe; r_bi = rbi;
    #(CLK_PERIOD/4);
    coll = !lce && !rce && (la == ra);
    lh   = m_pen[0] && !lce && (m_pad[0] == la);
    rh   = m_pen[1] && !rce && (m_pad[1] == ra);
    if (!coll)             nxt = 0;
    else if (m_owner != 0) nxt = m_owner;
    else if (rh && !lh)    nxt = 2;
    else                   nxt = 1;
    check(tag, "left gated write",  l_wg, lwe | (mst ? (nxt == 2) : !lbi));
    check(tag, "right gated write", r_wg, rwe | (mst ? (nxt == 1) : !rbi));
    @(posedge clk);
    #1;
    m_owner = nxt;
    m_pen[0] = !lce; m_pad[0] = la;
    m_pen[1] = !rce; m_pad[1] = ra;
    check(tag, "left busy",  l_bo, !(mst && nxt == 2));
    check(tag, "right busy", r_bo, !(mst && nxt == 1));
    check("R7", "busy exclusive", l_bo | r_bo, 1'b1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "left busy in reset",  l_bo, 1'b1);
    check("R1", "right busy in reset", r_bo, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, nothing held
    step("R1", 1, 1,0,1,1, 1,0,1,1);
    // R2: distinct addresses, both enabled, both writing
    step("R2", 1, 0,1,0,1, 0,2,0,1);
    step("R2", 1, 0,3,0,1, 0,0,0,1);
    // R2: same address, one enable off
    step("R2", 1, 0,2,0,1, 1,2,0,1);
    step("R2", 1, 1,2,0,1, 0,2,0,1);
    // R3: right settled on 1, left joins -> left loses
    step("R3", 1, 1,0,1,1, 0,1,0,1);
    step("R3", 1, 0,1,0,1, 0,1,0,1);
    // R5: hold while write strobes toggle
    step("R5", 1, 0,1,1,1, 0,1,0,1);
    step("R5", 1, 0,1,0,1, 0,1,1,1);
    step("R5", 1, 0,1,0,1, 0,1,0,1);
    // R9: release by address mismatch
    step("R9", 1, 0,2,0,1, 0,1,0,1);
    // R3 mirror: left settled on 2, right joins -> right loses
    step("R3", 1, 0,2,0,1, 0,2,0,1);
    step("R8", 1, 0,2,0,1, 0,2,0,1);
    // R9: release by enable off
    step("R9", 1, 1,2,0,1, 0,2,0,1);
    step("R9", 1, 1,0,1,1, 1,0,1,1);
    // R4 + R6: same-cycle arrival under each write combination
    for (int k = 0; k < 4; k++) begin
      step("R6", 1, 1,0,1,1, 1,0,1,1);
      step("R4", 1, 0,3,k[0],1, 0,3,k[1],1);
      step("R6", 1, 0,3,k[1],1, 0,3,k[0],1);
    end
    // R11: busy inputs low in master mode have no effect
    step("R11", 1, 1,0,1,1, 1,0,1,1);
    step("R11", 1, 0,0,0,0, 0,1,0,0);
    // R10: slave mode
    step("R10", 0, 0,1,0,1, 0,1,0,1);
    step("R10", 0, 0,1,0,0, 0,1,0,1);
    step("R10", 0, 0,1,0,1, 0,1,0,0);
    step("R10", 0, 0,2,0,0, 0,3,0,0);
    step("R10", 1, 1,0,1,1, 1,0,1,1);
    // sweep over a small address space
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R8", (lf[15:13] != 3'b000),
           (lf[1:0] == 2'b00), lf[3:2], lf[4], lf[5] | lf[6],
           (lf[8:7] == 2'b00), (lf[11] ? lf[3:2] : lf[10:9]), lf[12], lf[13] | lf[14]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule